// File: doc/BRIEF.md
# Three-Level Line Transmit Serializer

This block turns a stream of 5-bit code groups into a serial three-level line signal. It runs on one fast bit clock. A divide-by-five counter inside the block produces a slow word clock, and the block drives that clock out to the upstream coding logic. The upstream logic presents one code group per word-clock period on a parallel input.

Each group first lands in a holding register. It then moves into a parallel-in serial-out shifter, which sends it out least significant bit first. The serial bit drives a toggle stage: a one flips a binary line state and a zero leaves it alone. Each flip of that binary state advances a three-level line code by one step through a fixed rotation. A zero bit therefore holds the line level, and a run of ones walks it through zero, positive, zero, negative and back.

Top module: `mlt3_tx_serializer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows `line_sym` = 2'b00 and `word_clk_o` = 0. After reset, as long as only zero bits have been sent, `line_sym` stays 2'b00.
- R2: `word_clk_o` repeats every 5 bit-clock cycles. It is high for 2 cycles and low for 3. Its first rising edge comes at the first clock edge after reset is released.
- R3: `tx_word` is sampled once per word period, at the third rising bit-clock edge after the edge on which `word_clk_o` rose. Changing `tx_word` after that edge has no effect on the group already captured.
- R4: Each captured group is sent as 5 serial bits, bit 0 (least significant) first, one bit per bit-clock cycle, with no gap between groups.
- R5: A 0 bit leaves `line_sym` unchanged from the symbol of the previous bit.
- R6: A 1 bit moves `line_sym` one step along the rotation 0, +1, 0, -1, 0. The codes are 2'b00 = 0, 2'b01 = +1 and 2'b11 = -1. Code 2'b10 never appears.
- R7: The symbol for bit 0 of a group shows on `line_sym` after the seventh rising bit-clock edge that follows the edge on which `word_clk_o` rose before that group was presented.
- R8: A reset in the middle of a stream puts the line back to level 0 with the next step positive. The first 1 bit after reset therefore gives +1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_word | input | 5 | Code group from upstream, bit 0 sent first |
| word_clk_o | output | 1 | Word clock, bit clock divided by five |
| line_sym | output | 2 | Three-level line symbol: 00 = 0, 01 = +1, 11 = -1 |

## Verification
The hardest case to reach from the ports is a change of `tx_word` after the holding register has captured it, while the previous group is still leaving the shifter. The driver makes this happen on every group. It presents the group just after the word clock rises. It then drives the bitwise complement of that group once the capture edge has passed, and the scoreboard still expects the original group. A second hard case is the rotation state after a reset in the middle of a stream. The bench resets the block while it is sending all-one groups, then checks that the first step afterwards is positive.

// File: rtl/mlt3_tx_pkg.sv
// Package: shared types for the three-level line transmit serializer.
// Assumes: line codes are two-bit two's-complement values -1, 0 and +1.
package mlt3_tx_pkg;

    // Three-level line symbol; the encoding is visible at the top-level port.
    typedef enum logic [1:0] {
        LVL_ZERO = 2'b00,
        LVL_POS  = 2'b01,
        LVL_NEG  = 2'b11
    } mlt_level_t;

endpackage

// File: rtl/mlt3_word_clk_div.sv
// Module: divides the bit clock by WORD_W. It produces the word clock
// output, the strobe that captures the input group and the strobe that
// loads the shifter.
// Assumes: WORD_W >= 3. Reset leaves the counter at its last value, so
// the first edge after reset wraps it, raises the word clock and loads
// the shifter.
module mlt3_word_clk_div #(
    parameter int WORD_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic word_clk_o,
    output logic cap_stb_o,
    output logic load_stb_o
);
    localparam int CNT_W   = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int WCLK_HI = WORD_W / 2;
    localparam int CAP_AT  = WORD_W / 2;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             wclk_q;

    // Next counter value, wrapping after the last bit of a group.
    always_comb begin
        cnt_next = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end

    // Bit counter and registered word clock, high for the first WCLK_HI bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= CNT_LAST;
            wclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_next;
            wclk_q <= (32'(cnt_next) < WCLK_HI);
        end
    end

    // Strobes: capture in mid-period, load the shifter on wrap.
    always_comb begin
        cap_stb_o  = rst_n && (cnt_q == CNT_W'(CAP_AT));
        load_stb_o = rst_n && (cnt_q == CNT_LAST);
    end

    assign word_clk_o = wclk_q;

endmodule

// File: rtl/mlt3_hold_piso.sv
// Module: holding register followed by a parallel-in serial-out shifter.
// Sends bit 0 first.
// Assumes: cap_stb and load_stb never rise in the same cycle. The holding
// register is always captured at least one cycle before the shifter loads
// from it.
module mlt3_hold_piso #(
    parameter int WORD_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_stb,
    input  logic              load_stb,
    input  logic [WORD_W-1:0] word_i,
    output logic              bit_o
);
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] shreg_q;

    // Holding register: samples the input group once per word period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (cap_stb) begin
            hold_q <= word_i;
        end
    end

    // Shifter: loads on wrap, otherwise shifts toward bit 0 and fills with 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (load_stb) begin
            shreg_q <= hold_q;
        end else begin
            shreg_q <= {1'b0, shreg_q[WORD_W-1:1]};
        end
    end

    assign bit_o = shreg_q[0];

endmodule

// File: rtl/mlt3_line_enc.sv
// Module: NRZ-to-NRZI toggle stage chained into a three-level rotation
// encoder.
// Assumes: one serial bit per clock. Each change of the NRZI state moves
// the line one step along 0, +1, 0, -1.
module mlt3_line_enc
    import mlt3_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_i,
    output logic [1:0] line_sym_o
);
    logic       nrzi_q;
    logic       nrzi_d1;
    logic       step;
    logic       up_next_q;
    mlt_level_t level_q;

    // NRZI state: toggles on a one bit; keeps a delayed copy to see changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nrzi_q  <= 1'b0;
            nrzi_d1 <= 1'b0;
        end else begin
            nrzi_q  <= nrzi_q ^ bit_i;
            nrzi_d1 <= nrzi_q;
        end
    end

    // Step request: a change of NRZI state between consecutive bits.
    always_comb begin
        step = nrzi_q ^ nrzi_d1;
    end

    // Rotation state: current level and direction of the next non-zero step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q   <= LVL_ZERO;
            up_next_q <= 1'b1;
        end else if (step) begin
            unique case (level_q)
                LVL_ZERO: level_q <= up_next_q ? LVL_POS : LVL_NEG;
                LVL_POS: begin
                    level_q   <= LVL_ZERO;
                    up_next_q <= 1'b0;
                end
                LVL_NEG: begin
                    level_q   <= LVL_ZERO;
                    up_next_q <= 1'b1;
                end
                default: level_q <= LVL_ZERO;
            endcase
        end
    end

    assign line_sym_o = level_q;

endmodule

// File: rtl/mlt3_tx_serializer.sv
// Module: top of the transmit serializer. It takes a WORD_W-bit group
// every word period and sends a three-level line symbol every bit clock.
// Assumes: the upstream logic changes tx_word on the rising edge of
// word_clk_o, and the block samples it later in the same period.
module mlt3_tx_serializer #(
    parameter int WORD_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tx_word,
    output logic              word_clk_o,
    output logic [1:0]        line_sym
);
    logic cap_stb;
    logic load_stb;
    logic ser_bit;

    mlt3_word_clk_div #(.WORD_W(WORD_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_clk_o (word_clk_o),
        .cap_stb_o  (cap_stb),
        .load_stb_o (load_stb)
    );

    mlt3_hold_piso #(.WORD_W(WORD_W)) u_piso (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_stb  (cap_stb),
        .load_stb (load_stb),
        .word_i   (tx_word),
        .bit_o    (ser_bit)
    );

    mlt3_line_enc u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_i      (ser_bit),
        .line_sym_o (line_sym)
    );

endmodule

// File: rtl/mlt3_tx_serializer_chk.sv
// Module: assertion checker bound to the serializer top.
// Assumes: it is attached through the bind below and sees the NRZI
// registers of the encoder.
module mlt3_tx_serializer_chk #(
    parameter int WORD_W = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       word_clk_o,
    input logic [1:0] line_sym,
    input logic       nrzi_now,
    input logic       nrzi_prev
);
    logic [7:0] since_rise_q;
    logic       seen_rise_q;

    // Counts bit clocks since the last rise of the word clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rise_q <= '0;
            seen_rise_q  <= 1'b0;
        end else if (word_clk_o && !seen_rise_q) begin
            since_rise_q <= 8'd1;
            seen_rise_q  <= 1'b1;
        end else if ($rose(word_clk_o)) begin
            since_rise_q <= 8'd1;
        end else begin
            since_rise_q <= since_rise_q + 8'd1;
        end
    end

    // R1: reset clears the line and the word clock.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (line_sym == 2'b00 && !word_clk_o));

    // R2: the word clock rises once every WORD_W bit clocks.
    p_word_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(word_clk_o) && seen_rise_q) |-> (since_rise_q == 8'(WORD_W)));

    // R5: no NRZI change means the line holds its level on the next cycle.
    p_zero_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nrzi_now == nrzi_prev) |=> $stable(line_sym));

    // R6: the unused code never appears.
    p_legal_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        line_sym != 2'b10);

    // R6: the line never jumps directly between +1 and -1.
    p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(($past(line_sym) == 2'b01 && line_sym == 2'b11) ||
          ($past(line_sym) == 2'b11 && line_sym == 2'b01)));

endmodule

bind mlt3_tx_serializer mlt3_tx_serializer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_clk_o (word_clk_o),
    .line_sym   (line_sym),
    .nrzi_now   (u_enc.nrzi_q),
    .nrzi_prev  (u_enc.nrzi_d1)
);

// File: tb/mlt3_tx_serializer_test.sv
// Bench: a scoreboard for the serializer. A driver task presents groups
// and pushes the symbols a reference rotation model expects. A monitor
// pops those symbols and compares them with the line output.
module mlt3_tx_serializer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] tx_word = '0;
    logic       word_clk_o;
    logic [1:0] line_sym;

    int n_checks = 0;
    int n_fails  = 0;

    logic [1:0] exp_q[$];
    logic [4:0] words[$];
    int         ref_idx;

    mlt3_tx_serializer #(.WORD_W(5)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_word    (tx_word),
        .word_clk_o (word_clk_o),
        .line_sym   (line_sym)
    );

    always #2.5 clk = ~clk;

    // Counts one check and prints a FAIL line when it does not match.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference rotation: 0, +1, 0, -1 coded 00, 01, 00, 11.
    function automatic logic [1:0] ref_sym(input int idx);
        case (idx)
            1: return 2'b01;
            3: return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    // Driver: presents each group after the word clock rises, pushes the
    // expected symbols, then drives the complement after the capture edge (R3).
    task automatic drive_words();
        foreach (words[w]) begin
            @(posedge word_clk_o);
            @(negedge clk);
            tx_word = words[w];
            for (int b = 0; b < 5; b++) begin
                if (words[w][b]) ref_idx = (ref_idx + 1) % 4;
                exp_q.push_back(ref_sym(ref_idx));
            end
            repeat (3) @(posedge clk);
            @(negedge clk);
            tx_word = ~words[w];
        end
    endtask

    // Monitor: the line is quiet for seven edges (R1, R7), then each symbol
    // is compared with the scoreboard (R4, R5, R6, R3).
    task automatic monitor(input int n_bits);
        @(posedge word_clk_o);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            check("R1/R7 quiet before first bit", 32'(line_sym), 32'd0);
        end
        for (int i = 0; i < n_bits; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
                check("R4 scoreboard underflow", 32'd0, 32'd1);
            end else begin
                check("R4/R5/R6 line symbol", 32'(line_sym), 32'(exp_q.pop_front()));
            end
        end
    endtask

    // Runs one stream from a freshly reset line state.
    task automatic run_stream();
        ref_idx = 0;
        exp_q.delete();
        fork
            drive_words();
            monitor(words.size() * 5);
        join
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        n_fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        logic [9:0] pat;
        // Reset state (R1).
        repeat (3) @(negedge clk);
        check("R1 reset line", 32'(line_sym), 32'd0);
        check("R1 reset word clock", 32'(word_clk_o), 32'd0);

        // Word clock shape: rises on the first edge after release (R2).
        rst_n = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            pat[k] = word_clk_o;
        end
        check("R2 word clock 2 high 3 low", 32'(pat), 32'b0001100011);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check("R1 zero input keeps line at 0", 32'(line_sym), 32'd0);
        end

        // Reset again so the stream starts right at the first word-clock rise.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Stream A: corner patterns, then pseudo-random groups.
        words = '{5'b00000, 5'b11111, 5'b11111, 5'b00001, 5'b10000,
                  5'b10101, 5'b01010, 5'b00000, 5'b00011, 5'b11000};
        lfsr = 8'hA5;
        for (int i = 0; i < 20; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            words.push_back(lfsr[4:0]);
        end
        run_stream();

        // Reset while all-one groups are streaming (R8).
        tx_word = 5'b11111;
        repeat (13) @(negedge clk);
        rst_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 line zero in reset", 32'(line_sym), 32'd0);
            check("R8 word clock low in reset", 32'(word_clk_o), 32'd0);
        end
        rst_n = 1'b1;

        // Stream B: the first one bit after reset must step to +1 (R8).
        words = '{5'b11111, 5'b11111, 5'b00100, 5'b11111};
        run_stream();

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule